// File: doc/BRIEF.md
# Masked Bit Test-and-Set Unit

This block owns a small file of 40-bit data registers and performs one read-modify-write operation on them. Each register has an 8-bit extension field in bits 39:32, a high half in bits 31:16 and a low half in bits 15:0. Each register also has a one-bit limit flag. An operation names a register, a 16-bit mask and a half. The unit reads the register and forces to one every bit of the chosen half where the mask is one. It writes the word back, clears that register's limit flag, and records in a status register whether all the masked bits were already one before the write.

Operations enter through a valid/ready handshake. Each one takes two cycles: a read cycle and then a write-back cycle. A separate load port fills a register and its limit flag. A registered inspection port returns any register with its limit flag, so a host or a bench can see the file's state.

Top module: `mask_tset_unit`

## Requirements
- R1: In the half selected by `op_hi` (1 selects bits 31:16, 0 selects bits 15:0), every bit position where `op_mask` is 1 holds 1 after write-back.
- R2: Bit positions where `op_mask` is 0 keep the value they had before the operation.
- R3: Status bit 1 (the test flag) becomes 1 when every mask-selected bit was already 1 in the value read, and 0 otherwise. Example: 0x00_1234_5678 with mask 0x111F on the low half becomes 0x00_1234_577F and the flag is 0.
- R4: The extension bits 39:32, the unselected half and all other registers are unchanged by an operation.
- R5: The destination register's limit flag reads 0 after the operation. The limit flags of other registers are unchanged.
- R6: Status bits other than bit 1 never change and stay 0 after reset.
- R7: An operation is accepted on a rising edge where `op_valid` and `op_ready` are both 1. `op_ready` is 0 in the following cycle (write-back) and 1 again in the cycle after that. The register, the limit flag and the status bit are updated at the write-back edge.
- R8: An operation accepted right after the previous write-back, on the same register, reads the value that the previous operation wrote.
- R9: An all-zero mask leaves the register value unchanged, sets the test flag to 1 and still clears the limit flag.
- R10: A synchronous active-high `rst` clears all registers, all limit flags and the status register, and leaves `op_ready` at 1.
- R11: `ld_en` writes `ld_data` and `ld_limit` into register `ld_idx` at the next edge. The bench loads only while no operation is in flight. `insp_data` and `insp_limit` show register `insp_idx` one edge after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_idx | input | IDX_W | Destination register index |
| op_mask | input | 16 | Bit mask for the chosen half |
| op_hi | input | 1 | 1: high half, 0: low half |
| ld_en | input | 1 | Load a register |
| ld_idx | input | IDX_W | Register to load |
| ld_data | input | 40 | Word to load |
| ld_limit | input | 1 | Limit flag value to load |
| insp_idx | input | IDX_W | Register to inspect |
| insp_data | output | 40 | Inspected word (registered) |
| insp_limit | output | 1 | Inspected limit flag (registered) |
| status | output | SR_W | Status register, test flag at bit 1 |

## Verification
Assertions check on every write-back cycle that the masked bits come out as ones, that unmasked bits, the extension and the other half pass through unchanged, that the handshake drops ready for exactly one cycle, that a file write lands at its address, and that no status bit other than the test flag moves. The bench scenarios are the only way to show the test flag's value for a given mask and the clearing of the addressed limit flag while other flags stay set. They also show a back-to-back operation on the same register seeing the first result, the zero-mask case and the reset state, because each of these needs values that were set up across several operations.

// File: rtl/mtset_pkg.sv
package mtset_pkg;
  localparam int EXT_W  = 8;
  localparam int HALF_W = 16;
  localparam int WORD_W = EXT_W + 2 * HALF_W;

  typedef struct packed {
    logic [EXT_W-1:0]  ext;
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
  } dword_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WB = 1'b1} phase_t;
endpackage

// File: rtl/mtset_alu.sv
module mtset_alu
  import mtset_pkg::*;
(
  input  dword_t            old_w,
  input  logic [HALF_W-1:0] mask,
  input  logic              sel_hi,
  output dword_t            new_w,
  output logic              all_set
);
  logic [HALF_W-1:0] half_in;

  always_comb begin
    half_in = sel_hi ? old_w.hi : old_w.lo;
    new_w   = old_w;
    if (sel_hi) new_w.hi = old_w.hi | mask;
    else        new_w.lo = old_w.lo | mask;
    all_set = ((half_in & mask) == mask);
  end
endmodule

// File: rtl/mtset_rf.sv
module mtset_rf
  import mtset_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  dword_t           wdata,
  input  logic             wlim,
  input  logic [IDX_W-1:0] raddr_a,
  output dword_t           rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output dword_t           rdata_b,
  output logic             rlim_b
);
  dword_t              mem [NUM_REGS];
  logic [NUM_REGS-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      lim <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
      lim[waddr] <= wlim;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
      rlim_b  <= 1'b0;
    end else begin
      rdata_a <= mem[raddr_a];
      rdata_b <= mem[raddr_b];
      rlim_b  <= lim[raddr_b];
    end
  end

  // R11: a write is visible at its address after the edge
  a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)) && (lim[$past(waddr)] == $past(wlim)));
endmodule

// File: rtl/mtset_ctrl.sv
module mtset_ctrl
  import mtset_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  output logic op_ready,
  output logic accept,
  output logic wb_en
);
  phase_t phase;

  assign op_ready = (phase == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign wb_en    = (phase == ST_WB);

  always_ff @(posedge clk) begin
    if (rst)         phase <= ST_IDLE;
    else if (accept) phase <= ST_WB;
    else             phase <= ST_IDLE;
  end

  // R7: ready drops for the write-back cycle, then returns
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> !op_ready);
  a_r7_ready_returns: assert property (@(posedge clk) disable iff (rst)
    !op_ready |=> op_ready);
endmodule

// File: rtl/mask_tset_unit.sv
module mask_tset_unit
  import mtset_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int SR_W      = 32,
  parameter int TFLAG_BIT = 1,
  localparam int IDX_W = $clog2(NUM_REGS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [IDX_W-1:0]  op_idx,
  input  logic [HALF_W-1:0] op_mask,
  input  logic              op_hi,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_limit,
  input  logic [IDX_W-1:0]  insp_idx,
  output logic [WORD_W-1:0] insp_data,
  output logic              insp_limit,
  output logic [SR_W-1:0]   status
);
  localparam logic [SR_W-1:0] T_MASK = SR_W'(1) << TFLAG_BIT;

  logic              accept, wb_en;
  logic [IDX_W-1:0]  idx_q;
  logic [HALF_W-1:0] mask_q;
  logic              hi_q;
  dword_t            rd_w, new_w, insp_w;
  logic              all_set;
  logic              we, wlim;
  logic [IDX_W-1:0]  waddr;
  dword_t            wdata;

  mtset_ctrl u_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .accept(accept), .wb_en(wb_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      mask_q <= '0;
      hi_q   <= 1'b0;
    end else if (accept) begin
      idx_q  <= op_idx;
      mask_q <= op_mask;
      hi_q   <= op_hi;
    end
  end

  // write-back owns the single write port; loads use it otherwise
  always_comb begin
    we    = wb_en || ld_en;
    waddr = wb_en ? idx_q : ld_idx;
    wdata = wb_en ? new_w : dword_t'(ld_data);
    wlim  = wb_en ? 1'b0  : ld_limit;
  end

  mtset_rf #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata), .wlim(wlim),
    .raddr_a(op_idx), .rdata_a(rd_w),
    .raddr_b(insp_idx), .rdata_b(insp_w), .rlim_b(insp_limit)
  );

  assign insp_data = insp_w;

  mtset_alu u_alu (
    .old_w(rd_w), .mask(mask_q), .sel_hi(hi_q), .new_w(new_w), .all_set(all_set)
  );

  always_ff @(posedge clk) begin
    if (rst)        status <= '0;
    else if (wb_en) status[TFLAG_BIT] <= all_set;
  end

  // R1: masked bits of the chosen half leave as ones
  a_r1_mask_forced: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (((hi_q ? new_w.hi : new_w.lo) & mask_q) == mask_q));
  // R2: unmasked bits of the chosen half pass through
  a_r2_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ((((hi_q ? new_w.hi : new_w.lo) ^ (hi_q ? rd_w.hi : rd_w.lo)) & ~mask_q) == '0));
  // R4: extension and the other half pass through
  a_r4_rest_kept: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (new_w.ext == rd_w.ext) && (hi_q ? (new_w.lo == rd_w.lo) : (new_w.hi == rd_w.hi)));
  // R6: only the test flag may move
  a_r6_status_others: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(status & ~T_MASK));
endmodule

// File: tb/sim_mask_tset_unit.sv
`timescale 1ns/1ps
module sim_mask_tset_unit;
  localparam int IDX_W = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_ready, op_hi;
  logic [3:0]  op_idx;
  logic [15:0] op_mask;
  logic        ld_en, ld_limit;
  logic [3:0]  ld_idx, insp_idx;
  logic [39:0] ld_data, insp_data;
  logic        insp_limit;
  logic [31:0] status;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  mask_tset_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_idx(op_idx), .op_mask(op_mask), .op_hi(op_hi),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .ld_limit(ld_limit),
    .insp_idx(insp_idx), .insp_data(insp_data), .insp_limit(insp_limit),
    .status(status)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] i, input logic [39:0] d, input logic lim);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = i; ld_data = d; ld_limit = lim;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] i, output logic [39:0] d, output logic lim);
    @(negedge clk);
    insp_idx = i;
    @(posedge clk);
    #1;
    d = insp_data; lim = insp_limit;
  endtask

  // single operation; returns after the write-back edge
  task automatic run_op(input logic [3:0] i, input logic [15:0] m, input logic hi);
    @(negedge clk);
    op_valid = 1'b1; op_idx = i; op_mask = m; op_hi = hi;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [39:0] d; logic l;
    chk(op_ready == 1'b1, "R10 ready", 64'(op_ready), 64'd1);
    chk(status == 32'h0, "R10 status", 64'(status), 64'd0);
    peek(4'd7, d, l);
    chk(d == 40'h0 && l == 1'b0, "R10 reg7 cleared", {l, d}, 64'd0);
  endtask

  task automatic t_worked_case();
    logic [39:0] d; logic l;
    load(4'd1, 40'h00_1234_5678, 1'b1);
    peek(4'd1, d, l);
    chk(d == 40'h00_1234_5678 && l, "R11 load", {l, d}, {24'd1, 40'h00_1234_5678});
    run_op(4'd1, 16'h111F, 1'b0);
    chk(status == 32'h0, "R3 test flag clear", 64'(status), 64'd0);
    peek(4'd1, d, l);
    chk(d == 40'h00_1234_577F, "R1 R2 low half set", 64'(d), 64'h00_1234_577F);
    chk(l == 1'b0, "R5 limit cleared", 64'(l), 64'd0);
    run_op(4'd1, 16'h111F, 1'b0);
    chk(status == 32'h2, "R3 all already set", 64'(status), 64'd2);
    peek(4'd1, d, l);
    chk(d == 40'h00_1234_577F, "R3 value unchanged", 64'(d), 64'h00_1234_577F);
  endtask

  task automatic t_high_half();
    logic [39:0] d; logic l;
    load(4'd2, 40'hA5_0000_FFFF, 1'b0);
    run_op(4'd2, 16'h8001, 1'b1);
    chk(status == 32'h0, "R3 high half flag", 64'(status), 64'd0);
    peek(4'd2, d, l);
    chk(d == 40'hA5_8001_FFFF, "R4 high half only", 64'(d), 64'hA5_8001_FFFF);
    peek(4'd1, d, l);
    chk(d == 40'h00_1234_577F, "R4 other reg kept", 64'(d), 64'h00_1234_577F);
  endtask

  task automatic t_zero_mask();
    logic [39:0] d; logic l;
    load(4'd3, 40'h11_2222_3333, 1'b1);
    load(4'd5, 40'h0, 1'b1);
    run_op(4'd3, 16'h0000, 1'b1);
    chk(status == 32'h2, "R9 zero mask flag", 64'(status), 64'd2);
    peek(4'd3, d, l);
    chk(d == 40'h11_2222_3333 && !l, "R9 zero mask value", {l, d}, 64'h11_2222_3333);
    peek(4'd5, d, l);
    chk(l == 1'b1, "R5 other limit kept", 64'(l), 64'd1);
  endtask

  task automatic t_back_to_back();
    logic [39:0] d; logic l;
    load(4'd4, 40'hFF_0000_0000, 1'b0);
    @(negedge clk);
    op_valid = 1'b1; op_idx = 4'd4; op_mask = 16'h00F0; op_hi = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(op_ready == 1'b0, "R7 busy in write-back", 64'(op_ready), 64'd0);
    op_mask = 16'h00F0;
    @(posedge clk);
    @(negedge clk);
    chk(op_ready == 1'b1, "R7 ready again", 64'(op_ready), 64'd1);
    chk(status == 32'h0, "R8 first flag", 64'(status), 64'd0);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(status == 32'h2, "R8 second sees update", 64'(status), 64'd2);
    peek(4'd4, d, l);
    chk(d == 40'hFF_0000_00F0, "R8 value", 64'(d), 64'hFF_0000_00F0);
    chk((status & ~32'h2) == 32'h0, "R6 other status bits", 64'(status), 64'd2);
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_idx = '0; op_mask = '0; op_hi = 1'b0;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0; ld_limit = 1'b0; insp_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_worked_case();
    t_high_half();
    t_zero_mask();
    t_back_to_back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule